// File: doc/BRIEF.md
# Memory-Card Host Status Flag Unit

This block holds the status flags of a memory-card host controller. The command and data engines around it raise single-cycle event strobes: a command finished going out, the card response ended, a data transfer started, the CRC16 calculation finished, a CRC status token arrived, the transmit word was drained, and a receive word was captured. The bus side raises access strobes when software writes the command register, writes the transmit data register, reads the receive data register, or reads the status word. The unit turns these into six flags and presents them as one status word.

Five of the flags are sticky set/clear bits. Each has one event that sets it and one that clears it. When both arrive in the same cycle, the set event wins, so no event is lost. The sixth flag, not-busy, follows the card's busy signalling on the DAT0 line during write transfers. A response end clears it. It sets again once the card lets DAT0 rise after holding it low, and the rise counts only after the synchronized line has been high on two consecutive clocks. Outside write transfers the flag is frozen.

Top module: `sd_status_flags`

## Requirements
- R1: After reset the status word reads 0x00000025: command ready (bit 0), transmit ready (bit 2) and not busy (bit 5) are set, and all other bits are clear.
- R2: Command ready (bit 0) clears on the edge after a command-register write strobe. It sets on the edge after a command-sent event.
- R3: Receive ready (bit 1) sets on the edge after a receive-word event. It clears on the edge after a receive-register read strobe.
- R4: Transmit ready (bit 2) clears on the edge after a transmit-register write strobe. It sets on the edge after a transmit-drained event.
- R5: Transfer in progress (bit 4) sets on the edge after a transfer-start event. It clears on the edge after a CRC16-done event.
- R6: Block ended (bit 3) sets on the edge after each CRC status token event. It clears on the edge after a status-read strobe. The word seen during the read cycle still shows the bit before it clears.
- R7: While the write-transfer input is high, a response-end event clears not busy (bit 5) on the next edge.
- R8: During a write transfer, not busy sets only after DAT0 has been low and then high long enough for the two-stage synchronized copy to be high on two consecutive edges. When DAT0 rises and then stays high, the flag reads 0 after the first, second and third clock edges and reads 1 after the fourth. A high pulse lasting one clock does not set it. A DAT0 line that never went low does not set it.
- R9: While the write-transfer input is low, not busy keeps its value: neither response-end events nor DAT0 activity change it.
- R10: Bits 31 to 6 of the status word always read zero.
- R11: When a flag's set event and clear event arrive in the same cycle, the flag is set after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_cmd_sent | input | 1 | Command fully sent (strobe) |
| ev_resp_end | input | 1 | Card response ended (strobe) |
| ev_xfer_start | input | 1 | Data transfer started (strobe) |
| ev_crc16_done | input | 1 | CRC16 calculation finished (strobe) |
| ev_crc_tok | input | 1 | CRC status token received (strobe) |
| ev_tx_drained | input | 1 | Transmit word moved out (strobe) |
| ev_rx_word | input | 1 | Receive word captured (strobe) |
| wr_xfer_i | input | 1 | High while a write transfer is active |
| dat0_i | input | 1 | Card DAT0 line, asynchronous |
| acc_cmd_wr | input | 1 | Command register written (strobe) |
| acc_tx_wr | input | 1 | Transmit data register written (strobe) |
| acc_rx_rd | input | 1 | Receive data register read (strobe) |
| acc_stat_rd | input | 1 | Status word read (strobe) |
| stat_o | output | 32 | Status word |

## Verification
Each of the five sticky flags is driven into both starting states. From each state it gets all four combinations of its set and clear strobes. This separates a flag that ignores its clear, one that ignores its set, and one that lets the clear win when both strobes arrive together. The whole 32-bit word is compared each time, so any effect on a neighbouring bit shows up as well. The not-busy flag is tried with DAT0 high pulses of one to four clocks. These tell apart a detector that needs two synchronized high samples from one that needs only one or that drops the synchronizer. A step-by-step latency run and a DAT0 line that never goes low check the exact edge on which the flag rises and that release counts only after a low period. The same stimuli with the write-transfer input low confirm that the flag stays frozen.

// File: rtl/sdsf_pkg.sv
package sdsf_pkg;
    localparam int STAT_W = 32;

    // packed so that the struct maps straight onto status bits 5..0
    typedef struct packed {
        logic not_busy;   // bit 5
        logic xfer_act;   // bit 4
        logic blk_end;    // bit 3
        logic tx_rdy;     // bit 2
        logic rx_rdy;     // bit 1
        logic cmd_rdy;    // bit 0
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);
    localparam flags_t FLAGS_RST = '{not_busy: 1'b1, xfer_act: 1'b0, blk_end: 1'b0,
                                     tx_rdy: 1'b1, rx_rdy: 1'b0, cmd_rdy: 1'b1};
endpackage

// File: rtl/sdsf_sync.sv
module sdsf_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[i] <= RST_VAL;
                end else if (i == 0) begin
                    chain_q[i] <= async_i;
                end else begin
                    chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdsf_rise_det.sv
module sdsf_rise_det #(
    parameter int HIGH_RUN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic release_o
);
    localparam int CNT_W = $clog2(HIGH_RUN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(HIGH_RUN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HIGH_RUN - 1);

    logic [CNT_W-1:0] run_d, run_q;

    always_comb begin
        if (!lvl_i) begin
            run_d = '0;
        end else if (run_q != CNT_MAX) begin
            run_d = run_q + 1'b1;
        end else begin
            run_d = run_q;
        end
    end

    // pulses once, on the sample that completes the high run
    assign release_o = lvl_i && (run_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= CNT_MAX;   // line assumed idle high: no spurious release
        end else begin
            run_q <= run_d;
        end
    end
endmodule

// File: rtl/sd_status_flags.sv
module sd_status_flags
    import sdsf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HIGH_RUN    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_cmd_sent,
    input  logic              ev_resp_end,
    input  logic              ev_xfer_start,
    input  logic              ev_crc16_done,
    input  logic              ev_crc_tok,
    input  logic              ev_tx_drained,
    input  logic              ev_rx_word,
    input  logic              wr_xfer_i,
    input  logic              dat0_i,
    input  logic              acc_cmd_wr,
    input  logic              acc_tx_wr,
    input  logic              acc_rx_rd,
    input  logic              acc_stat_rd,
    output logic [STAT_W-1:0] stat_o
);
    logic   dat0_sync;
    logic   busy_release;
    flags_t set_v, clr_v;
    flags_t flags_d, flags_q;

    sdsf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (dat0_i),
        .sync_o  (dat0_sync)
    );

    sdsf_rise_det #(.HIGH_RUN(HIGH_RUN)) u_rise (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (dat0_sync),
        .release_o (busy_release)
    );

    always_comb begin
        set_v = '{not_busy: wr_xfer_i & busy_release,
                  xfer_act: ev_xfer_start,
                  blk_end:  ev_crc_tok,
                  tx_rdy:   ev_tx_drained,
                  rx_rdy:   ev_rx_word,
                  cmd_rdy:  ev_cmd_sent};
        clr_v = '{not_busy: wr_xfer_i & ev_resp_end,
                  xfer_act: ev_crc16_done,
                  blk_end:  acc_stat_rd,
                  tx_rdy:   acc_tx_wr,
                  rx_rdy:   acc_rx_rd,
                  cmd_rdy:  acc_cmd_wr};
        // set dominates clear on every flag
        flags_d = set_v | (flags_q & ~clr_v);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= FLAGS_RST;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign stat_o = {{(STAT_W-FLAG_W){1'b0}}, flags_q};
endmodule

// File: rtl/sdsf_checker.sv
module sdsf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_cmd_sent,
    input logic        ev_xfer_start,
    input logic        ev_crc16_done,
    input logic        ev_crc_tok,
    input logic        ev_tx_drained,
    input logic        ev_rx_word,
    input logic        wr_xfer_i,
    input logic        acc_cmd_wr,
    input logic        acc_tx_wr,
    input logic        acc_rx_rd,
    input logic        acc_stat_rd,
    input logic [31:0] stat_o
);
    assert_cmd_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_cmd_wr && !ev_cmd_sent |=> !stat_o[0]);
    assert_cmd_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cmd_sent |=> stat_o[0]);
    assert_rx_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_word |=> stat_o[1]);
    assert_rx_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rx_rd && !ev_rx_word |=> !stat_o[1]);
    assert_tx_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_drained |=> stat_o[2]);
    assert_tx_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_tx_wr && !ev_tx_drained |=> !stat_o[2]);
    assert_blk_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_crc_tok |=> stat_o[3]);
    assert_blk_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stat_rd && !ev_crc_tok |=> !stat_o[3]);
    assert_xfer_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_xfer_start |=> stat_o[4]);
    assert_xfer_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_crc16_done && !ev_xfer_start |=> !stat_o[4]);
    assert_nb_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_xfer_i |=> $stable(stat_o[5]));
endmodule

bind sd_status_flags sdsf_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_cmd_sent   (ev_cmd_sent),
    .ev_xfer_start (ev_xfer_start),
    .ev_crc16_done (ev_crc16_done),
    .ev_crc_tok    (ev_crc_tok),
    .ev_tx_drained (ev_tx_drained),
    .ev_rx_word    (ev_rx_word),
    .wr_xfer_i     (wr_xfer_i),
    .acc_cmd_wr    (acc_cmd_wr),
    .acc_tx_wr     (acc_tx_wr),
    .acc_rx_rd     (acc_rx_rd),
    .acc_stat_rd   (acc_stat_rd),
    .stat_o        (stat_o)
);

// File: tb/sd_status_flags_tb_top.sv
module sd_status_flags_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_cmd_sent = 0, ev_resp_end = 0, ev_xfer_start = 0, ev_crc16_done = 0;
    logic ev_crc_tok = 0, ev_tx_drained = 0, ev_rx_word = 0;
    logic wr_xfer_i = 0, dat0_i = 1;
    logic acc_cmd_wr = 0, acc_tx_wr = 0, acc_rx_rd = 0, acc_stat_rd = 0;
    logic [31:0] stat_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    logic [5:0] exp_f;

    always #10 clk = ~clk;   // 50 MHz

    sd_status_flags dut_i (
        .clk(clk), .rst_n(rst_n),
        .ev_cmd_sent(ev_cmd_sent), .ev_resp_end(ev_resp_end),
        .ev_xfer_start(ev_xfer_start), .ev_crc16_done(ev_crc16_done),
        .ev_crc_tok(ev_crc_tok), .ev_tx_drained(ev_tx_drained),
        .ev_rx_word(ev_rx_word), .wr_xfer_i(wr_xfer_i), .dat0_i(dat0_i),
        .acc_cmd_wr(acc_cmd_wr), .acc_tx_wr(acc_tx_wr),
        .acc_rx_rd(acc_rx_rd), .acc_stat_rd(acc_stat_rd),
        .stat_o(stat_o)
    );

    task automatic check(input string req, input logic [31:0] expv);
        n_vec++;
        if (stat_o !== expv) begin
            n_bad++;
            $display("FAIL %s: stat_o=%08h expected %08h", req, stat_o, expv);
        end
    endtask

    function automatic string flag_req(input int f);
        case (f)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R6";
            default: return "R5";
        endcase
    endfunction

    // flag index: 0 cmd, 1 rx, 2 tx, 3 blk, 4 xfer
    task automatic drive_flag(input int f, input bit s, input bit c);
        string req;
        int bitpos;
        @(negedge clk);
        case (f)
            0: begin ev_cmd_sent = s;   acc_cmd_wr = c;    end
            1: begin ev_rx_word = s;    acc_rx_rd = c;     end
            2: begin ev_tx_drained = s; acc_tx_wr = c;     end
            3: begin ev_crc_tok = s;    acc_stat_rd = c;   end
            default: begin ev_xfer_start = s; ev_crc16_done = c; end
        endcase
        req = (s && c) ? {flag_req(f), "/R11"} : flag_req(f);
        // R6: during the read cycle the word still shows the old value
        if (f == 3 && c) check("R6 read-cycle value", {26'd0, exp_f});
        bitpos = (f == 3) ? 3 : (f == 4) ? 4 : (f == 2) ? 2 : f;
        exp_f[bitpos] = s | (exp_f[bitpos] & ~c);
        @(negedge clk);
        {ev_cmd_sent, acc_cmd_wr, ev_rx_word, acc_rx_rd, ev_tx_drained, acc_tx_wr} = '0;
        {ev_crc_tok, acc_stat_rd, ev_xfer_start, ev_crc16_done} = '0;
        check({req, " R10"}, {26'd0, exp_f});
    endtask

    task automatic resp_end(input bit wr);
        @(negedge clk);
        wr_xfer_i = wr;
        ev_resp_end = 1;
        if (wr) exp_f[5] = 1'b0;
        @(negedge clk);
        ev_resp_end = 0;
    endtask

    task automatic hold_dat(input bit v, input int n);
        @(negedge clk);
        dat0_i = v;
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin
        exp_f = 6'b100101;
        repeat (3) @(negedge clk);
        check("R1 reset value", 32'h0000_0025);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", 32'h0000_0025);

        // sticky flags: both start states, all set/clear combos
        for (int f = 0; f < 5; f++) begin
            for (int init = 0; init < 2; init++) begin
                for (int combo = 0; combo < 4; combo++) begin
                    drive_flag(f, init[0], !init[0]);
                    drive_flag(f, combo[1], combo[0]);
                end
            end
        end
        // R6: repeated CRC tokens keep it set, a read clears
        drive_flag(3, 1, 0);
        drive_flag(3, 1, 0);
        drive_flag(3, 0, 1);

        // R7 clear on response end during a write
        wr_xfer_i = 1;
        dat0_i = 1;
        resp_end(1);
        check("R7 response end clears not busy", {26'd0, exp_f});

        // R8 line never went low: no set
        repeat (6) @(negedge clk);
        check("R8 no release without low period", {26'd0, exp_f});

        // R8 exact latency
        hold_dat(0, 4);
        @(negedge clk);
        dat0_i = 1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (k == 4) exp_f[5] = 1'b1;
            check($sformatf("R8 latency edge %0d", k), {26'd0, exp_f});
        end

        // R8 pulse widths 1..4 during a write; R9 same with write low
        for (int wr = 1; wr >= 0; wr--) begin
            for (int len = 1; len <= 4; len++) begin
                wr_xfer_i = 1;
                resp_end(1);                 // start from cleared
                hold_dat(0, 4);
                wr_xfer_i = wr[0];
                hold_dat(1, len);
                hold_dat(0, 5);
                if (wr == 1 && len >= 2) exp_f[5] = 1'b1;
                check($sformatf("%s pulse len %0d", (wr == 1) ? "R8" : "R9", len),
                      {26'd0, exp_f});
            end
        end

        // R9 flag set, write low: response end has no effect
        wr_xfer_i = 1;
        hold_dat(1, 5);
        hold_dat(0, 3);
        hold_dat(1, 6);
        exp_f[5] = 1'b1;
        check("R8 set before R9 check", {26'd0, exp_f});
        resp_end(0);
        @(negedge clk);
        check("R9 response end ignored outside write", {26'd0, exp_f});

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        done = 1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule